// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked request port and an external 128K x 8 asynchronous static RAM. The RAM has one active-low chip enable, one active-high chip enable, an active-low output enable and an active-low write enable. It has a single bidirectional byte lane. The controller accepts one request at a time through a valid/ready handshake, then drives the address, the selects and the strobes for the request. It holds every phase for a whole number of clock cycles.

The phase lengths come from the memory's nanosecond limits and the clock period. They are computed at elaboration, each one rounded up and never less than one cycle. Before any write, the RAM's output drivers are turned off by raising the output enable, and the controller waits out the high-impedance time before it enables its own data drivers. A read returns its data with a one-cycle valid strobe.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, the memory is deselected (chip enable low-active output high, high-active output low), output enable and write enable are high, the data drivers are off and `req_ready_o` is high.
- R2: A request is taken on a rising edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` then stays low for exactly max(cycle-time count, phase sum) cycles. For a read the phase sum is the access count; for a write it is turnaround + pulse + 1.
- R3: A read (`req_we_i`=0) selects the memory, holds write enable high, keeps the data drivers off and holds output enable low with a stable address for exactly the access count. The access count is max(ceil(T_AA_NS/CLK_PERIOD_NS), ceil(T_ACE_NS/CLK_PERIOD_NS)).
- R4: Read data is captured on the edge that ends the access count. `rsp_valid_o` goes high for exactly one cycle, starting one cycle after that edge, and `rsp_rdata_o` then shows the byte stored at the address.
- R5: The data drivers are never on while output enable is low. Before a write, output enable stays high with the chip selected and the drivers off for at least the turnaround count, ceil(T_OHZ_NS/CLK_PERIOD_NS).
- R6: A write (`req_we_i`=1) holds write enable low for exactly the pulse count, with the chip selected and the write byte on the driven bus, so the byte is stored at the address. The pulse count is max(ceil(T_WP_NS/P), ceil(T_DW_NS/P), ceil(T_AW_NS/P) - turnaround, 1), where P is CLK_PERIOD_NS.
- R7: The memory address does not change while write enable is low.
- R8: After write enable rises, the drivers stay on for one more cycle. After each transaction the memory is deselected with the drivers off.
- R9: Each count is the ceiling of its nanosecond limit divided by the clock period, with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | One-cycle read-data strobe |
| rsp_rdata_o | output | 8 | Read byte |
| mem_addr_o | output | 17 | Memory address |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_ce2_o | output | 1 | Chip enable, active high |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Bus value driven by the controller |
| mem_dq_i | input | 8 | Bus value sampled from the memory |
| mem_dq_oe_o | output | 1 | Enables the controller's bus drivers |

## Verification
The bench sweeps 64 writes across spread-out addresses with arithmetically derived bytes, then reads all 64 back. This separates address-path faults from data-path faults, because each address holds a different byte. Writes of 00, FF, AA and 55 at the lowest and highest addresses, each read back at once, catch stuck bits and write-then-read ordering faults. On every transaction the bench counts the cycles of each strobe and the turnaround gap, which tells phase-count errors apart from bus-contention and select-polarity errors.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_PULSE,
    ST_HOLD,
    ST_PAD
  } ctrl_st_e;

  // ceil(ns / period), never below one cycle
  function automatic int ns2cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R2
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/sram_ctrl_rdcap.sv
module sram_ctrl_rdcap #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) data_o <= dq_i;
    end
  end

  // R4
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  parameter int TURN_C = 4,
  parameter int RD_C   = 7,
  parameter int WP_C   = 5,
  parameter int RD_PAD = 0,
  parameter int WR_PAD = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  input  logic              tmr_zero_i,
  output logic              tmr_load_o,
  output logic [CNT_W-1:0]  tmr_val_o,
  output logic              cap_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_ce2_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o
);
  localparam logic [CNT_W-1:0] TURN_V   = CNT_W'(TURN_C - 1);
  localparam logic [CNT_W-1:0] RD_V     = CNT_W'(RD_C - 1);
  localparam logic [CNT_W-1:0] WP_V     = CNT_W'(WP_C - 1);
  localparam logic [CNT_W-1:0] RD_PAD_V = CNT_W'((RD_PAD > 0) ? RD_PAD - 1 : 0);
  localparam logic [CNT_W-1:0] WR_PAD_V = CNT_W'((WR_PAD > 0) ? WR_PAD - 1 : 0);

  ctrl_st_e          st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              ce_n_q, ce_n_d, ce2_q, ce2_d;
  logic              oe_n_q, oe_n_d, we_n_q, we_n_d;
  logic              drv_q, drv_d;

  always_comb begin
    st_d       = st_q;
    addr_d     = addr_q;
    wdata_d    = wdata_q;
    ce_n_d     = ce_n_q;
    ce2_d      = ce2_q;
    oe_n_d     = oe_n_q;
    we_n_d     = we_n_q;
    drv_d      = drv_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    cap_o      = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        addr_d     = req_addr_i;
        ce_n_d     = 1'b0;
        ce2_d      = 1'b1;
        tmr_load_o = 1'b1;
        if (req_we_i) begin
          wdata_d   = req_wdata_i;
          oe_n_d    = 1'b1;
          tmr_val_o = TURN_V;
          st_d      = ST_TURN;
        end else begin
          oe_n_d    = 1'b0;
          tmr_val_o = RD_V;
          st_d      = ST_RD;
        end
      end
      ST_RD: if (tmr_zero_i) begin
        cap_o  = 1'b1;
        ce_n_d = 1'b1;
        ce2_d  = 1'b0;
        oe_n_d = 1'b1;
        if (RD_PAD > 0) begin
          tmr_load_o = 1'b1;
          tmr_val_o  = RD_PAD_V;
          st_d       = ST_PAD;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_TURN: if (tmr_zero_i) begin
        we_n_d     = 1'b0;
        drv_d      = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = WP_V;
        st_d       = ST_PULSE;
      end
      ST_PULSE: if (tmr_zero_i) begin
        we_n_d = 1'b1;
        st_d   = ST_HOLD;
      end
      ST_HOLD: begin
        drv_d  = 1'b0;
        ce_n_d = 1'b1;
        ce2_d  = 1'b0;
        if (WR_PAD > 0) begin
          tmr_load_o = 1'b1;
          tmr_val_o  = WR_PAD_V;
          st_d       = ST_PAD;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_PAD: if (tmr_zero_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      ce_n_q  <= 1'b1;
      ce2_q   <= 1'b0;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      drv_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      ce_n_q  <= ce_n_d;
      ce2_q   <= ce2_d;
      oe_n_q  <= oe_n_d;
      we_n_q  <= we_n_d;
      drv_q   <= drv_d;
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_addr_o  = addr_q;
  assign mem_ce_n_o  = ce_n_q;
  assign mem_ce2_o   = ce2_q;
  assign mem_oe_n_o  = oe_n_q;
  assign mem_we_n_o  = we_n_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = drv_q;

  // R5
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_q |-> oe_n_q);
  // R6
  we_selected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_q |-> (!ce_n_q && ce2_q && drv_q));
  // R7
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_q |=> (we_n_q || $stable(addr_q)));
  // R8
  deselect_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n_q |-> (!ce2_q && we_n_q && oe_n_q && !drv_q));
  // R8
  hold_after_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_q) |-> drv_q);
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_AA_NS       = 70,
  parameter int T_ACE_NS      = 70,
  parameter int T_RC_NS       = 70,
  parameter int T_OHZ_NS      = 35,
  parameter int T_WP_NS       = 45,
  parameter int T_DW_NS       = 30,
  parameter int T_AW_NS       = 60,
  parameter int T_WC_NS       = 70
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_ce2_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);
  // R9: cycle counts from ns limits
  localparam int TURN_C  = ns2cyc(T_OHZ_NS, CLK_PERIOD_NS);
  localparam int RD_C    = imax(ns2cyc(T_AA_NS, CLK_PERIOD_NS), ns2cyc(T_ACE_NS, CLK_PERIOD_NS));
  localparam int RC_C    = ns2cyc(T_RC_NS, CLK_PERIOD_NS);
  localparam int WP_C    = imax(imax(ns2cyc(T_WP_NS, CLK_PERIOD_NS), ns2cyc(T_DW_NS, CLK_PERIOD_NS)),
                                imax(ns2cyc(T_AW_NS, CLK_PERIOD_NS) - TURN_C, 1));
  localparam int WC_C    = ns2cyc(T_WC_NS, CLK_PERIOD_NS);
  localparam int WR_SPAN = TURN_C + WP_C + 1;
  localparam int RD_PAD  = imax(RC_C - RD_C, 0);
  localparam int WR_PAD  = imax(WC_C - WR_SPAN, 0);
  localparam int MAX_C   = imax(imax(TURN_C, WP_C), imax(RD_C, imax(RD_PAD, WR_PAD)));
  localparam int CNT_W   = $clog2(MAX_C + 1);

  logic             tmr_load, tmr_zero, cap;
  logic [CNT_W-1:0] tmr_val;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  sram_ctrl_fsm #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .CNT_W (CNT_W),
    .TURN_C (TURN_C), .RD_C (RD_C), .WP_C (WP_C),
    .RD_PAD (RD_PAD), .WR_PAD (WR_PAD)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_ready_o (req_ready_o),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .cap_o       (cap),
    .mem_addr_o  (mem_addr_o),
    .mem_ce_n_o  (mem_ce_n_o),
    .mem_ce2_o   (mem_ce2_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .mem_we_n_o  (mem_we_n_o),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o)
  );

  sram_ctrl_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .dq_i    (mem_dq_i),
    .valid_o (rsp_valid_o),
    .data_o  (rsp_rdata_o)
  );
endmodule

// File: tb/sram_ctrl_tb_top.sv
module sram_ctrl_tb_top;
  localparam int P     = 10;
  localparam int WIN   = 16;
  // expected counts, R9: ceil(ns/P), min 1
  function automatic int cy(input int ns);
    int c; c = (ns + P - 1) / P; return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  localparam int E_TURN = cy(35);
  localparam int E_RD   = mx(cy(70), cy(70));
  localparam int E_WP   = mx(mx(cy(45), cy(30)), mx(cy(60) - E_TURN, 1));
  localparam int E_WBSY = mx(cy(70), E_TURN + E_WP + 1);
  localparam int E_RBSY = mx(cy(70), E_RD);

  logic        clk_i = 0, rst_ni = 0;
  logic        req_valid_i = 0, req_we_i = 0;
  logic [16:0] req_addr_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic        req_ready_o, rsp_valid_o;
  logic [7:0]  rsp_rdata_o;
  logic [16:0] mem_addr_o;
  logic        mem_ce_n_o, mem_ce2_o, mem_oe_n_o, mem_we_n_o, mem_dq_oe_o;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] mdl   [int];
  logic [7:0] ref_m [int];

  always #(P/2) clk_i = ~clk_i;

  sram_ctrl dut_i (.*);

  // memory model: stores at end of write, drives bus on read
  always @(posedge mem_we_n_o)
    if (!mem_ce_n_o && mem_ce2_o && mem_dq_oe_o) mdl[int'(mem_addr_o)] = mem_dq_o;
  always @(negedge clk_i)
    if (!mem_ce_n_o && mem_ce2_o && !mem_oe_n_o && mem_we_n_o)
      mem_dq_i <= mdl.exists(int'(mem_addr_o)) ? mdl[int'(mem_addr_o)] : 8'h00;
    else
      mem_dq_i <= 8'h00;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_check(input string tag);
    check(mem_ce_n_o && !mem_ce2_o && mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o,
          tag, {mem_ce_n_o, mem_ce2_o, mem_oe_n_o, mem_we_n_o, mem_dq_oe_o}, 5'b10110);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    int rdy_low = 0, we_low = 0, cont = 0, bad = 0, run = 0, turn = -1, hold = 0;
    logic prev_drv = 0;
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1; req_we_i = 1; req_addr_i = a; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 0; req_addr_i = ~a; req_wdata_i = ~d;
    for (int k = 1; k <= WIN; k++) begin
      if (!req_ready_o) rdy_low++;
      if (mem_dq_oe_o && !mem_oe_n_o) cont++;
      if (!mem_we_n_o) begin
        we_low++;
        if (mem_ce_n_o || !mem_ce2_o || !mem_dq_oe_o || mem_addr_o != a || mem_dq_o != d) bad++;
      end
      if (mem_dq_oe_o && mem_we_n_o) hold++;
      if (!mem_ce_n_o && mem_ce2_o && mem_oe_n_o && !mem_dq_oe_o) run++;
      if (mem_dq_oe_o && !prev_drv) turn = run;
      prev_drv = mem_dq_oe_o;
      @(negedge clk_i);
    end
    ref_m[int'(a)] = d;
    check(rdy_low == E_WBSY, "R2 write busy cycles", rdy_low, E_WBSY);
    check(cont == 0, "R5 drivers on with OE low", cont, 0);
    check(turn >= E_TURN, "R5 turnaround before drive", turn, E_TURN);
    check(we_low == E_WP, "R6 R9 write pulse cycles", we_low, E_WP);
    check(bad == 0, "R6 R7 select/addr/data during pulse", bad, 0);
    check(mdl.exists(int'(a)) && mdl[int'(a)] == d, "R6 stored byte",
          mdl.exists(int'(a)) ? int'(mdl[int'(a)]) : -1, int'(d));
    check(hold == 1, "R8 drive hold after WE rise", hold, 1);
    idle_check("R8 deselected after write");
  endtask

  task automatic do_read(input logic [16:0] a);
    int rdy_low = 0, oe_low = 0, rv_cnt = 0, rv_at = 0, bad = 0;
    logic [7:0] got = '0, exp;
    exp = ref_m.exists(int'(a)) ? ref_m[int'(a)] : 8'h00;
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1; req_we_i = 0; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 0; req_addr_i = ~a;
    for (int k = 1; k <= WIN; k++) begin
      if (!req_ready_o) rdy_low++;
      if (!mem_oe_n_o) begin
        oe_low++;
        if (mem_ce_n_o || !mem_ce2_o || !mem_we_n_o || mem_dq_oe_o || mem_addr_o != a) bad++;
      end
      if (rsp_valid_o) begin
        rv_cnt++;
        if (rv_at == 0) begin rv_at = k; got = rsp_rdata_o; end
      end
      @(negedge clk_i);
    end
    check(rdy_low == E_RBSY, "R2 read busy cycles", rdy_low, E_RBSY);
    check(oe_low == E_RD, "R3 R9 OE low cycles", oe_low, E_RD);
    check(bad == 0, "R3 read strobes/addr", bad, 0);
    check(rv_cnt == 1 && rv_at == E_RD + 1, "R4 read valid timing", rv_at, E_RD + 1);
    check(got == exp, "R4 read data", int'(got), int'(exp));
    idle_check("R8 deselected after read");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    idle_check("R1 pins in reset");
    check(req_ready_o == 1'b1, "R1 ready in reset", req_ready_o, 1);
    rst_ni = 1;
    @(negedge clk_i);
    idle_check("R1 pins after reset");
    check(req_ready_o == 1'b1, "R1 ready after reset", req_ready_o, 1);
    for (int i = 0; i < 64; i++) do_write(17'(i * 2053), 8'((i * 29 + 7) & 255));
    for (int i = 0; i < 64; i++) do_read(17'(i * 2053));
    for (int j = 0; j < 4; j++) begin
      logic [7:0] pat;
      pat = (j == 0) ? 8'h00 : (j == 1) ? 8'hFF : (j == 2) ? 8'hAA : 8'h55;
      do_write(17'h00000, pat);
      do_read(17'h00000);
      do_write(17'h1FFFF, ~pat);
      do_read(17'h1FFFF);
      do_read(17'h00000);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule